// File: doc/BRIEF.md
# Parallel Thread Dispatch Controller

This controller sits between a serial master and a group of parallel execution units. The master issues a spawn carrying a thread count and a code start address. Once the spawn is accepted, the controller puts both values on one shared broadcast bus seen by every unit. Each unit takes its own index as its first thread ID. Units whose index is not below the count have nothing to run and go idle at once.

When a unit finishes a thread, it asks for another ID. The controller hands out IDs from a shared counter that starts just past the initial assignment. Each request works as an atomic fetch-and-increment, so load balancing happens at run time. Units run at their own pace. When several units ask in the same cycle, they get consecutive IDs in ascending unit order, in that same cycle. An ID at or beyond the thread count tells the unit to stop, and the unit then counts as having reached the join.

When every unit is idle, the controller gives the master a one-cycle join pulse and drops its busy flag. A second spawn while one is active is rejected, because spawns cannot be nested.

Top module: `thread_dispatch`

## Requirements
- R1: With `busy` low, a spawn request is accepted in the same cycle (`spawnAccept` high) and `busy` is high from the next cycle.
- R2: In the cycle after an accepted spawn, `bcastValid` is high for exactly one cycle, with `bcastCount` and `bcastAddr` equal to the spawned count and address. Both values hold until the next accepted spawn.
- R3: After an accepted spawn with count n, `unitIdle[i]` is 0 exactly for the units with i < n. With n = 0, every unit stays idle.
- R4: Active units requesting in a cycle each get `grantValid` in that same cycle. Their IDs are consecutive in ascending unit-index order and start at the shared counter, which is the unit count (8) right after a spawn. The counter then advances by the number of grants.
- R5: `grantLive[i]` is 1 exactly when the granted ID is below n. A unit whose grant is not live is idle from the next cycle.
- R6: A request from an idle unit is ignored: no `grantValid` for it, and the shared counter does not advance.
- R7: A spawn request while `busy` is high raises `spawnReject` in that cycle, is not accepted, and leaves the broadcast values unchanged.
- R8: In the cycle after all units have become idle during an active spawn, `joinDone` is high for one cycle and `busy` is low from that same cycle.
- R9: After reset, `busy` is low, every unit is idle, and no accept, reject, broadcast or join pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawnValid | input | 1 | Master requests a spawn |
| spawnCount | input | 32 | Number of virtual threads n |
| spawnAddr | input | 32 | Code start address |
| spawnAccept | output | 1 | Spawn taken this cycle |
| spawnReject | output | 1 | Spawn refused (a spawn is active) |
| busy | output | 1 | A spawn is in progress |
| bcastValid | output | 1 | Broadcast strobe to all units |
| bcastCount | output | 32 | Broadcast thread count |
| bcastAddr | output | 32 | Broadcast start address |
| reqValid | input | 8 | Per-unit request for the next thread ID |
| grantValid | output | 8 | Per-unit grant, same cycle as the request |
| grantId | output | 256 | Granted IDs, unit i in bits [32i+31:32i] |
| grantLive | output | 8 | Granted ID is a valid thread (below n) |
| unitIdle | output | 8 | Per-unit idle status |
| joinDone | output | 1 | One-cycle join pulse to the master |

## Verification
The grant logic is driven with a sparse mask (units 1, 3 and 6), with every unit at once, and with alternating halves of the active set. Together these separate correct prefix ranking from a scheme that counts every unit or only the lowest one. A grant that straddles the thread count shows whether the live/dead cut is at exactly n. Spawns with n = 0, n below the unit count and n above it each test the initial idle mask and the join timing. Requests from idle units and a nested spawn show that ignored stimulus leaves the counter and the broadcast values untouched.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic loadSpawn;  // latch count/address and reset the ID counter
    logic advance;    // bump the ID counter by the number of grants
  } dpCtrl_t;
endpackage

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int ID_W      = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpCtrl_t                   ctl,
  input  logic [NUM_UNITS-1:0]      grantMask,
  input  logic [ID_W-1:0]           spawnCount,
  input  logic [ADDR_W-1:0]         spawnAddr,
  output logic [ID_W-1:0]           bcastCount,
  output logic [ADDR_W-1:0]         bcastAddr,
  output logic [NUM_UNITS*ID_W-1:0] grantId,
  output logic [NUM_UNITS-1:0]      grantLive
);
  localparam int CW    = ID_W + 1;              // counter never wraps
  localparam int RNK_W = $clog2(NUM_UNITS + 1);

  logic [CW-1:0]    nextId;
  logic [RNK_W-1:0] rank [NUM_UNITS];
  logic [RNK_W-1:0] total;
  logic [CW-1:0]    idExt [NUM_UNITS];

  // Exclusive prefix count of the grant mask gives each grant its offset
  always_comb begin
    logic [RNK_W-1:0] run;
    run = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      rank[i] = run;
      run     = run + RNK_W'(grantMask[i]);
    end
    total = run;
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_grant
    assign idExt[g]                   = nextId + CW'(rank[g]);
    assign grantId[g*ID_W +: ID_W]    = idExt[g][ID_W-1:0];
    assign grantLive[g]               = idExt[g] < {1'b0, bcastCount};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextId     <= '0;
      bcastCount <= '0;
      bcastAddr  <= '0;
    end else if (ctl.loadSpawn) begin
      nextId     <= CW'(NUM_UNITS);
      bcastCount <= spawnCount;
      bcastAddr  <= spawnAddr;
    end else if (ctl.advance) begin
      nextId     <= nextId + CW'(total);
    end
  end
endmodule

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int ID_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spawnValid,
  input  logic [ID_W-1:0]      spawnCount,
  input  logic [NUM_UNITS-1:0] reqValid,
  input  logic [NUM_UNITS-1:0] grantLive,
  output dpCtrl_t              ctl,
  output logic [NUM_UNITS-1:0] grantMask,
  output logic                 spawnAccept,
  output logic                 spawnReject,
  output logic                 busy,
  output logic                 bcastValid,
  output logic                 joinDone,
  output logic [NUM_UNITS-1:0] unitIdle
);
  logic [NUM_UNITS-1:0] active;
  logic [NUM_UNITS-1:0] initMask;
  logic [NUM_UNITS-1:0] retire;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_init
    assign initMask[g] = spawnCount > ID_W'(g);
  end

  assign spawnAccept   = spawnValid && !busy;
  assign spawnReject   = spawnValid && busy;
  assign grantMask     = reqValid & active;
  assign retire        = grantMask & ~grantLive;
  assign unitIdle      = ~active;
  assign ctl.loadSpawn = spawnAccept;
  assign ctl.advance   = |grantMask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      active     <= '0;
      bcastValid <= 1'b0;
      joinDone   <= 1'b0;
    end else begin
      bcastValid <= spawnAccept;
      joinDone   <= 1'b0;
      if (spawnAccept) begin
        busy   <= 1'b1;
        active <= initMask;
      end else if (busy) begin
        active <= active & ~retire;
        if (active == '0) begin
          busy     <= 1'b0;
          joinDone <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch
  import tdc_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int ID_W      = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spawnValid,
  input  logic [ID_W-1:0]           spawnCount,
  input  logic [ADDR_W-1:0]         spawnAddr,
  output logic                      spawnAccept,
  output logic                      spawnReject,
  output logic                      busy,
  output logic                      bcastValid,
  output logic [ID_W-1:0]           bcastCount,
  output logic [ADDR_W-1:0]         bcastAddr,
  input  logic [NUM_UNITS-1:0]      reqValid,
  output logic [NUM_UNITS-1:0]      grantValid,
  output logic [NUM_UNITS*ID_W-1:0] grantId,
  output logic [NUM_UNITS-1:0]      grantLive,
  output logic [NUM_UNITS-1:0]      unitIdle,
  output logic                      joinDone
);
  dpCtrl_t ctl;

  tdc_control #(.NUM_UNITS(NUM_UNITS), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .spawnValid(spawnValid), .spawnCount(spawnCount),
    .reqValid(reqValid), .grantLive(grantLive), .ctl(ctl), .grantMask(grantValid),
    .spawnAccept(spawnAccept), .spawnReject(spawnReject), .busy(busy),
    .bcastValid(bcastValid), .joinDone(joinDone), .unitIdle(unitIdle)
  );

  tdc_datapath #(.NUM_UNITS(NUM_UNITS), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .grantMask(grantValid),
    .spawnCount(spawnCount), .spawnAddr(spawnAddr), .bcastCount(bcastCount),
    .bcastAddr(bcastAddr), .grantId(grantId), .grantLive(grantLive)
  );
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int NUM_UNITS = 8,
  parameter int ID_W      = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      spawnAccept,
  input logic                      spawnReject,
  input logic                      busy,
  input logic                      bcastValid,
  input logic [NUM_UNITS-1:0]      grantValid,
  input logic [NUM_UNITS*ID_W-1:0] grantId,
  input logic [NUM_UNITS-1:0]      unitIdle,
  input logic                      joinDone
);
  // R1: accept and reject never together, accept raises busy
  assert_accept_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(spawnAccept && spawnReject));
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spawnAccept |=> busy);
  // R2: broadcast strobe follows acceptance, single cycle
  assert_accept_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spawnAccept |=> bcastValid);
  assert_bcast_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bcastValid |=> !bcastValid);
  // R7: no second acceptance while a spawn is active
  assert_no_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spawnAccept |=> !spawnAccept);
  // R6: only working units receive grants
  assert_grant_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid & unitIdle) == '0);
  // R8: join pulse comes only with every unit idle, lasts one cycle
  assert_join_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    joinDone |-> (&unitIdle && !busy));
  assert_join_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    joinDone |=> !joinDone);
  // R4: neighbouring simultaneous grants carry consecutive IDs
  for (genvar g = 0; g < NUM_UNITS - 1; g++) begin : g_adj
    assert_adjacent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grantValid[g] && grantValid[g+1]) |->
      (grantId[(g+1)*ID_W +: ID_W] == grantId[g*ID_W +: ID_W] + ID_W'(1)));
  end
endmodule

bind thread_dispatch tdc_checker #(.NUM_UNITS(NUM_UNITS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spawnAccept(spawnAccept), .spawnReject(spawnReject),
  .busy(busy), .bcastValid(bcastValid), .grantValid(grantValid), .grantId(grantId),
  .unitIdle(unitIdle), .joinDone(joinDone)
);

// File: tb/tb_thread_dispatch.sv
`timescale 1ns/1ps
module tb_thread_dispatch;
  localparam int P  = 8;
  localparam int IW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spawnValid = 1'b0;
  logic [IW-1:0] spawnCount = '0;
  logic [AW-1:0] spawnAddr = '0;
  logic spawnAccept, spawnReject, busy, bcastValid, joinDone;
  logic [IW-1:0] bcastCount;
  logic [AW-1:0] bcastAddr;
  logic [P-1:0] reqValid = '0;
  logic [P-1:0] grantValid, grantLive, unitIdle;
  logic [P*IW-1:0] grantId;

  always #4 clk = ~clk;  // 125 MHz

  thread_dispatch dut (
    .clk(clk), .rst_n(rst_n), .spawnValid(spawnValid), .spawnCount(spawnCount),
    .spawnAddr(spawnAddr), .spawnAccept(spawnAccept), .spawnReject(spawnReject),
    .busy(busy), .bcastValid(bcastValid), .bcastCount(bcastCount),
    .bcastAddr(bcastAddr), .reqValid(reqValid), .grantValid(grantValid),
    .grantId(grantId), .grantLive(grantLive), .unitIdle(unitIdle),
    .joinDone(joinDone)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int          unit;
    logic [31:0] id;
    logic        live;
  } grantExp_t;
  grantExp_t expQ[$];

  // Bench model of the spawn state
  logic [31:0] mNext;
  logic [31:0] mCount;
  logic [P-1:0] mActive = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected grants in ascending unit order
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < P; i++) begin
        if (grantValid[i]) begin
          if (expQ.size() == 0) begin
            check(0, "R4", "unexpected grant unit", 64'(i), 64'hFFFF);
          end else begin
            grantExp_t e;
            e = expQ.pop_front();
            check(e.unit == i, "R4", "grant unit", 64'(i), 64'(e.unit));
            check(grantId[i*IW +: IW] == e.id, "R4", "grant id",
                  64'(grantId[i*IW +: IW]), 64'(e.id));
            check(grantLive[i] == e.live, "R5", "grant live",
                  64'(grantLive[i]), 64'(e.live));
          end
        end
      end
    end
  end

  task automatic doSpawn(input logic [31:0] n, input logic [31:0] a, input bit expAccept);
    logic [31:0] oldCount;
    logic [31:0] oldAddr;
    oldCount = bcastCount;
    oldAddr  = bcastAddr;
    @(posedge clk); #1;
    spawnValid = 1'b1; spawnCount = n; spawnAddr = a;
    @(negedge clk);
    check(spawnAccept == expAccept, "R1", "accept", 64'(spawnAccept), 64'(expAccept));
    check(spawnReject == !expAccept, "R7", "reject", 64'(spawnReject), 64'(!expAccept));
    @(posedge clk); #1;
    spawnValid = 1'b0;
    @(negedge clk);
    if (expAccept) begin
      for (int i = 0; i < P; i++) mActive[i] = (n > 32'(i));
      mNext  = P;
      mCount = n;
      check(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
      check(bcastValid == 1'b1, "R2", "bcast strobe", 64'(bcastValid), 64'd1);
      check(bcastCount == n, "R2", "bcast count", 64'(bcastCount), 64'(n));
      check(bcastAddr == a, "R2", "bcast addr", 64'(bcastAddr), 64'(a));
      check(unitIdle == ~mActive, "R3", "initial idle mask", 64'(unitIdle), 64'(~mActive));
    end else begin
      check(bcastValid == 1'b0, "R7", "no bcast on reject", 64'(bcastValid), 64'd0);
      check(bcastCount == oldCount, "R7", "count kept", 64'(bcastCount), 64'(oldCount));
      check(bcastAddr == oldAddr, "R7", "addr kept", 64'(bcastAddr), 64'(oldAddr));
    end
  endtask

  // Driver: requests from mask, pushes the expected grants
  task automatic doReq(input logic [P-1:0] mask);
    logic [P-1:0] eff;
    logic [P-1:0] nextActive;
    eff = mask & mActive;
    nextActive = mActive;
    @(posedge clk); #1;
    reqValid = mask;
    for (int i = 0; i < P; i++) begin
      if (eff[i]) begin
        grantExp_t e;
        e.unit = i;
        e.id   = mNext;
        e.live = (mNext < mCount);
        if (!e.live) nextActive[i] = 1'b0;
        expQ.push_back(e);
        mNext++;
      end
    end
    @(negedge clk);
    check(grantValid == eff, "R6", "grant pattern", 64'(grantValid), 64'(eff));
    mActive = nextActive;
  endtask

  task automatic expectJoin();
    @(negedge clk);
    check(joinDone == 1'b1, "R8", "join pulse", 64'(joinDone), 64'd1);
    check(busy == 1'b0, "R8", "busy cleared", 64'(busy), 64'd0);
    check(unitIdle == '1, "R8", "all idle at join", 64'(unitIdle), 64'hFF);
    @(negedge clk);
    check(joinDone == 1'b0, "R8", "join one cycle", 64'(joinDone), 64'd0);
  endtask

  task automatic drainAndJoin(input logic [P-1:0] pickA, input logic [P-1:0] pickB);
    while (mActive != '0) begin
      doReq(mActive & pickA);
      if (mActive != '0) doReq(mActive & pickB);
    end
    @(posedge clk); #1;
    reqValid = '0;
    @(negedge clk);
    check(joinDone == 1'b0, "R8", "no early join", 64'(joinDone), 64'd0);
    check(unitIdle == '1, "R5", "dead grant idles unit", 64'(unitIdle), 64'hFF);
    expectJoin();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 1'b0, "R9", "busy", 64'(busy), 64'd0);
    check(unitIdle == '1, "R9", "idle", 64'(unitIdle), 64'hFF);
    check(!(spawnAccept || spawnReject || bcastValid || joinDone), "R9", "pulses",
          64'({spawnAccept, spawnReject, bcastValid, joinDone}), 64'd0);

    // Main spawn, n above the unit count
    doSpawn(32'd20, 32'h0000_1000, 1'b1);
    doSpawn(32'd5, 32'h0000_2000, 1'b0);     // R7 nested spawn refused
    doReq(8'b0100_1010);                      // R4 sparse: 8,9,10
    doReq(8'hFF);                             // R4 all: 11..18
    doReq(8'b0000_0011);                      // R5 19 live, 20 dead
    doReq(8'b0000_0010);                      // R6 unit 1 now idle
    doReq(8'b0000_0100);                      // R6 counter unmoved: 21
    drainAndJoin(8'hFF, 8'hFF);

    // n = 0: nothing activates, join follows directly
    doSpawn(32'd0, 32'h0000_3000, 1'b1);
    check(joinDone == 1'b0, "R8", "join not in bcast cycle", 64'(joinDone), 64'd0);
    expectJoin();

    // n below the unit count
    doSpawn(32'd3, 32'h0000_4000, 1'b1);
    doReq(8'b0010_0000);                      // R6 idle unit 5 ignored
    doReq(8'b0000_0100);                      // R5 id 8 is dead for n=3
    drainAndJoin(8'hFF, 8'hFF);

    // Staggered halves, n = 30
    doSpawn(32'd30, 32'h0000_5000, 1'b1);
    drainAndJoin(8'h55, 8'hAA);

    check(expQ.size() == 0, "R4", "leftover expected grants", 64'(expQ.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule